// File: doc/BRIEF.md
# Erased-Valid 72/64 SEC-DED Codec

This block protects 64-bit words with 8 check bits using a modified Hamming code that corrects any one flipped bit and detects any two flipped bits. The check equations carry a fixed inversion mask, so a word that has been erased to all ones decodes as clean. In this code the all-ones data word has the all-ones check byte, so a blank check after an erase raises no flag.

The block has two independent streaming channels with valid/ready handshakes. The encode channel takes 64 data bits and returns a 72-bit codeword. The decode channel takes a 72-bit codeword and returns the corrected data, the raw 8-bit syndrome, a corrected flag and an uncorrectable flag.

Each channel has one output register. A word is accepted on a rising edge where its input valid and input ready are both high, and the result appears on the channel output in the following cycle. Input ready is high when the output register is empty or when its content is being taken in the same cycle. While output valid is high and output ready is low, the output holds its value. A stalled output therefore stalls its input after at most one accepted word, and no word is dropped.

Top module: `secded72_codec`

## Requirements
- R1: The encoder output is laid out as data in bits [63:0] and check bits in [71:64]. The check bits for an all-ones data word are 8'hFF.
- R2: Every codeword the encoder emits has even parity over all 72 bits.
- R3: The all-ones 72-bit codeword decodes with syndrome 0, both flags low and all-ones data.
- R4: An error-free codeword decodes with syndrome 0, both flags low and its data unchanged.
- R5: Hamming positions are numbered as follows. Data bit k takes the (k+1)-th integer of 3 or more that is not a power of two, so bit 0 is at position 3 and bit 63 at position 71. Check bit i (i<7) is at position 2^i, and check bit 7 is at position 0. A single flipped data bit gives syndrome[7]=1 and syndrome[6:0] equal to its position. It raises the corrected flag and returns the original data.
- R6: A single flipped check bit gives syndrome[7]=1 and syndrome[6:0] equal to its position. It raises the corrected flag and leaves the data output equal to the stored data.
- R7: Any two flipped bits give syndrome[7]=0 with a nonzero syndrome[6:0]. They raise the uncorrectable flag with the corrected flag low, and the received data bits pass through unmodified.
- R8: When syndrome[7]=1 and syndrome[6:0] is above 71, the uncorrectable flag is raised, the corrected flag stays low and no data bit is flipped.
- R9: On each channel, a word is accepted on an edge with input valid and input ready both high, and its result is valid in the next cycle. Input ready is high when the output is empty or is being taken. A stalled output (valid high, ready low) holds its value.
- R10: During reset, both output valids are low and all output payloads are zero. After reset, both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_in_valid | input | 1 | Encode input word present |
| enc_in_ready | output | 1 | Encode channel can accept |
| enc_in_data | input | 64 | Data word to encode |
| enc_out_valid | output | 1 | Codeword present |
| enc_out_ready | input | 1 | Consumer takes codeword |
| enc_out_code | output | 72 | Codeword {check[7:0], data[63:0]} |
| dec_in_valid | input | 1 | Decode input word present |
| dec_in_ready | output | 1 | Decode channel can accept |
| dec_in_code | input | 72 | Received codeword {check, data} |
| dec_out_valid | output | 1 | Decode result present |
| dec_out_ready | input | 1 | Consumer takes decode result |
| dec_out_data | output | 64 | Corrected data |
| dec_out_syndrome | output | 8 | Raw syndrome, bit 7 = overall parity |
| dec_out_corrected | output | 1 | Single error corrected |
| dec_out_uncorrectable | output | 1 | Error detected but not correctable |

## Verification
There are three kinds of internal fault, and each shows up at the ports.

- **Wrong parity-group membership or a wrong inversion mask.** This shows at the outputs one cycle after the affected word is accepted. The all-ones codeword would report a nonzero syndrome, or an emitted codeword would fail the parity or check-byte comparison.
- **Wrong position-to-bit mapping in the corrector.** This also shows on the next output beat, as a restored word that differs from the original in two bits, or as a flag in the wrong state.
- **A fault in an output register's enable.** This shows as a changed or missing result during a stall. It is caught on the first cycle in which the consumer holds ready low.

// File: rtl/secded72_pkg.sv
package secded72_pkg;

  localparam int unsigned DATA_W  = 64;
  localparam int unsigned HAM_W   = 7;
  localparam int unsigned CHK_W   = HAM_W + 1;
  localparam int unsigned CODE_W  = DATA_W + CHK_W;
  localparam int unsigned POS_MAX = (1 << HAM_W) - 1;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CHK_W-1:0]  syn_t;

  typedef struct packed {
    data_t data;
    syn_t  syn;
    logic  corr;
    logic  unc;
  } dec_res_t;

  // True for 0 and for powers of two (positions reserved for check bits).
  function automatic logic is_pow2(int unsigned p);
    return (p & (p - 1)) == 0;
  endfunction

  // Hamming position that holds data bit k.
  function automatic int unsigned data_pos(int unsigned k);
    int unsigned seen;
    int unsigned found;
    seen  = 0;
    found = 0;
    for (int unsigned p = 1; p <= POS_MAX; p++) begin
      if (!is_pow2(p)) begin
        if (seen == k) found = p;
        seen++;
      end
    end
    return found;
  endfunction

  // Plain Hamming parity groups over the data bits (no inversion applied).
  function automatic logic [HAM_W-1:0] ham_raw(data_t d);
    logic [HAM_W-1:0] acc;
    int unsigned      k;
    acc = '0;
    k   = 0;
    for (int unsigned p = 1; p <= POS_MAX; p++) begin
      if (!is_pow2(p) && (k < DATA_W)) begin
        for (int unsigned i = 0; i < HAM_W; i++) begin
          if (p[i]) acc[i] = acc[i] ^ d[k];
        end
        k++;
      end
    end
    return acc;
  endfunction

  // Inversion mask that makes all-ones data map to all-ones check bits.
  localparam logic [HAM_W-1:0] ERASE_FIX = ham_raw('1) ^ {HAM_W{1'b1}};

  // Highest Hamming position occupied by a data bit.
  localparam logic [HAM_W-1:0] LAST_POS = HAM_W'(data_pos(DATA_W - 1));

endpackage

// File: rtl/secded72_encoder.sv
module secded72_encoder
  import secded72_pkg::*;
(
  input  data_t data,
  output code_t code
);

  logic [HAM_W-1:0] grp;
  logic             overall;

  // Parity groups, inverted so the erased pattern is a codeword.
  assign grp     = ham_raw(data) ^ ERASE_FIX;
  // Overall bit makes the full 72-bit word even.
  assign overall = ^{data, grp};
  assign code    = {overall, grp, data};

endmodule

// File: rtl/secded72_syndrome.sv
module secded72_syndrome
  import secded72_pkg::*;
(
  input  code_t code,
  output syn_t  syn
);

  data_t            rx_data;
  logic [HAM_W-1:0] rx_grp;
  logic [HAM_W-1:0] recomputed;

  assign rx_data    = code[DATA_W-1:0];
  assign rx_grp     = code[DATA_W +: HAM_W];
  assign recomputed = ham_raw(rx_data) ^ ERASE_FIX;

  // Low bits: error position; top bit: parity of the whole received word.
  assign syn = {^code, recomputed ^ rx_grp};

endmodule

// File: rtl/secded72_corrector.sv
module secded72_corrector
  import secded72_pkg::*;
(
  input  data_t rx_data,
  input  syn_t  syn,
  output data_t fixed_data,
  output logic  corr,
  output logic  unc
);

  logic [HAM_W-1:0] where;
  logic             odd;
  logic             in_range;
  data_t            hit;

  assign where = syn[HAM_W-1:0];
  assign odd   = syn[CHK_W-1];

  // One comparator per data bit against its fixed Hamming position.
  for (genvar k = 0; k < DATA_W; k++) begin : g_flip
    localparam logic [HAM_W-1:0] POS_K = HAM_W'(data_pos(k));
    assign hit[k] = odd && in_range && (where == POS_K);
  end

  assign in_range   = (where <= LAST_POS);
  assign fixed_data = rx_data ^ hit;
  assign corr       = odd && in_range;
  assign unc        = (syn != '0) && !(odd && in_range);

endmodule

// File: rtl/secded72_stage.sv
module secded72_stage #(
  parameter int unsigned W       = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  if (OUT_REG) begin : g_reg
    logic         v_q;
    logic [W-1:0] d_q;

    assign in_ready  = !v_q || out_ready;
    assign out_valid = v_q;
    assign out_data  = d_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        if (in_ready) v_q <= in_valid;
        if (in_valid && in_ready) d_q <= in_data;
      end
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid); // R9
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end

endmodule

// File: rtl/secded72_codec.sv
module secded72_codec
  import secded72_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enc_in_valid,
  output logic               enc_in_ready,
  input  logic [DATA_W-1:0]  enc_in_data,
  output logic               enc_out_valid,
  input  logic               enc_out_ready,
  output logic [CODE_W-1:0]  enc_out_code,
  input  logic               dec_in_valid,
  output logic               dec_in_ready,
  input  logic [CODE_W-1:0]  dec_in_code,
  output logic               dec_out_valid,
  input  logic               dec_out_ready,
  output logic [DATA_W-1:0]  dec_out_data,
  output logic [CHK_W-1:0]   dec_out_syndrome,
  output logic               dec_out_corrected,
  output logic               dec_out_uncorrectable
);

  localparam int unsigned RES_W = $bits(dec_res_t);

  // ---------------- encode channel ----------------
  code_t enc_code;

  secded72_encoder u_enc (
    .data (enc_in_data),
    .code (enc_code)
  );

  secded72_stage #(.W(CODE_W), .OUT_REG(OUT_REG)) u_enc_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_data   (enc_code),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_data  (enc_out_code)
  );

  // ---------------- decode channel ----------------
  syn_t     dec_syn;
  data_t    dec_fixed;
  logic     dec_corr;
  logic     dec_unc;
  dec_res_t dec_res;
  dec_res_t dec_res_q;
  logic [RES_W-1:0] dec_res_bits;

  secded72_syndrome u_syn (
    .code (dec_in_code),
    .syn  (dec_syn)
  );

  secded72_corrector u_fix (
    .rx_data    (dec_in_code[DATA_W-1:0]),
    .syn        (dec_syn),
    .fixed_data (dec_fixed),
    .corr       (dec_corr),
    .unc        (dec_unc)
  );

  assign dec_res = '{data: dec_fixed, syn: dec_syn, corr: dec_corr, unc: dec_unc};

  secded72_stage #(.W(RES_W), .OUT_REG(OUT_REG)) u_dec_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_in_valid),
    .in_ready  (dec_in_ready),
    .in_data   (dec_res),
    .out_valid (dec_out_valid),
    .out_ready (dec_out_ready),
    .out_data  (dec_res_bits)
  );

  assign dec_res_q             = dec_res_bits;
  assign dec_out_data          = dec_res_q.data;
  assign dec_out_syndrome      = dec_res_q.syn;
  assign dec_out_corrected     = dec_res_q.corr;
  assign dec_out_uncorrectable = dec_res_q.unc;

  // ---------------- checks ----------------
  AST_ENC_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> !(^enc_out_code)); // R2

  AST_CLEAN_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_out_syndrome == '0) |-> (!dec_out_corrected && !dec_out_uncorrectable)); // R4

  AST_EVEN_NONZERO_UNC: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && !dec_out_syndrome[CHK_W-1] && dec_out_syndrome != '0)
      |-> (dec_out_uncorrectable && !dec_out_corrected)); // R7

  AST_FAR_POS_UNC: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_out_syndrome[CHK_W-1] && dec_out_syndrome[HAM_W-1:0] > LAST_POS)
      |-> (dec_out_uncorrectable && !dec_out_corrected)); // R8

  AST_ODD_NEAR_CORR: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_out_syndrome[CHK_W-1] && dec_out_syndrome[HAM_W-1:0] <= LAST_POS)
      |-> (dec_out_corrected && !dec_out_uncorrectable)); // R5

endmodule

// File: tb/tb_secded72_codec.sv
module tb_secded72_codec;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enc_in_valid, enc_in_ready, enc_out_valid, enc_out_ready;
  logic [63:0] enc_in_data;
  logic [71:0] enc_out_code;
  logic        dec_in_valid, dec_in_ready, dec_out_valid, dec_out_ready;
  logic [71:0] dec_in_code;
  logic [63:0] dec_out_data;
  logic [7:0]  dec_out_syndrome;
  logic        dec_out_corrected, dec_out_uncorrectable;

  always #10 clk = ~clk;

  secded72_codec dut (
    .clk(clk), .rst_n(rst_n),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_data(enc_in_data),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready), .enc_out_code(enc_out_code),
    .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready), .dec_in_code(dec_in_code),
    .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready), .dec_out_data(dec_out_data),
    .dec_out_syndrome(dec_out_syndrome), .dec_out_corrected(dec_out_corrected),
    .dec_out_uncorrectable(dec_out_uncorrectable)
  );

  typedef struct {
    logic [71:0] code;
    logic [63:0] data;
    logic [7:0]  syn;
    logic        corr;
    logic        unc;
    string       tag;
  } dexp_t;

  int          n_vec = 0;
  int          n_bad = 0;
  int unsigned pos[64];
  logic [63:0] enc_todo[$];
  logic [71:0] enc_exp[$];
  dexp_t       dec_todo[$];
  dexp_t       dec_exp[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Position numbering from R5.
  task automatic build_pos();
    int k = 0;
    for (int p = 3; p < 128 && k < 64; p++) begin
      if ($countones(p) != 1) begin
        pos[k] = p;
        k++;
      end
    end
  endtask

  function automatic logic [6:0] groups(logic [63:0] d);
    logic [6:0] g = '0;
    for (int k = 0; k < 64; k++)
      for (int i = 0; i < 7; i++)
        if (((pos[k] >> i) & 1) == 1) g[i] = g[i] ^ d[k];
    return g;
  endfunction

  // R1: all-ones data -> all-ones low check bits; R2: even overall parity.
  function automatic logic [71:0] encode(logic [63:0] d);
    logic [6:0] g = groups(d) ^ groups('1) ^ 7'h7F;
    logic       top = ^{d, g};
    return {top, g, d};
  endfunction

  function automatic logic [6:0] bit_pos(int b);
    if (b < 64)  return 7'(pos[b]);
    if (b == 71) return 7'd0;
    return 7'(1 << (b - 64));
  endfunction

  function automatic int data_index(int p);
    for (int k = 0; k < 64; k++) if (pos[k] == p) return k;
    return -1;
  endfunction

  // Build a decode vector; flip bits b0..b2 (-1 = unused).
  function automatic dexp_t mk_dec(logic [63:0] d, int b0, int b1, int b2, string tag);
    dexp_t e;
    int    fl[3] = '{b0, b1, b2};
    int    cnt = 0;
    logic [6:0] s = '0;
    int    di;
    e.code = encode(d);
    foreach (fl[j]) begin
      if (fl[j] >= 0) begin
        e.code[fl[j]] = ~e.code[fl[j]];
        s = s ^ bit_pos(fl[j]);
        cnt++;
      end
    end
    e.syn  = {1'(cnt % 2), s};
    e.data = e.code[63:0];
    e.corr = 1'b0;
    e.unc  = 1'b0;
    if (e.syn != 8'h00) begin
      if (!e.syn[7]) e.unc = 1'b1;
      else if (s > 7'd71) e.unc = 1'b1;
      else begin
        e.corr = 1'b1;
        di = data_index(int'(s));
        if (di >= 0) e.data[di] = ~e.data[di];
      end
    end
    e.tag = tag;
    return e;
  endfunction

  // Watchdog: counts as a failed check and still prints the summary.
  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog expired act=%0d exp=%0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] words[8];
    logic [63:0] enc_cur, enc_prev_data;
    dexp_t       dec_cur, ex;
    bit          enc_have, dec_have, enc_acc, dec_acc, enc_stall, dec_stall;
    logic [71:0] enc_prev;
    logic [63:0] dec_prev_d;
    logic [7:0]  dec_prev_s;

    build_pos();
    rst_n = 1'b0;
    enc_in_valid = 1'b0; enc_in_data = '0; enc_out_ready = 1'b0;
    dec_in_valid = 1'b0; dec_in_code = '0; dec_out_ready = 1'b0;

    repeat (3) @(negedge clk);
    #1;
    check(!enc_out_valid && !dec_out_valid, "R10", "valid in reset", {enc_out_valid, dec_out_valid}, 0);
    check(enc_out_code == '0, "R10", "enc payload in reset", enc_out_code, 0);
    check(dec_out_data == '0 && dec_out_syndrome == '0 && !dec_out_corrected && !dec_out_uncorrectable,
          "R10", "dec payload in reset", {dec_out_data, dec_out_syndrome}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(enc_in_ready && dec_in_ready, "R10", "ready after reset", {enc_in_ready, dec_in_ready}, 2'b11);

    words[0] = '1;
    words[1] = '0;
    words[2] = 64'hAAAA_AAAA_AAAA_AAAA;
    words[3] = 64'h5555_5555_5555_5555;
    for (int w = 4; w < 8; w++) words[w] = {$urandom, $urandom};

    foreach (words[w]) enc_todo.push_back(words[w]);
    for (int w = 0; w < 6; w++) enc_todo.push_back({$urandom, $urandom});

    // R3: literal erased codeword.
    ex.code = '1; ex.data = '1; ex.syn = '0; ex.corr = 1'b0; ex.unc = 1'b0; ex.tag = "R3";
    dec_todo.push_back(ex);
    foreach (words[w]) begin
      dec_todo.push_back(mk_dec(words[w], -1, -1, -1, (w == 0) ? "R3" : "R4"));
      for (int b = 0; b < 72; b++)
        dec_todo.push_back(mk_dec(words[w], b, -1, -1, (b < 64) ? "R5" : "R6"));
      for (int j = 0; j < 12; j++) begin
        int a = $urandom % 72;
        int c = (a + 1 + ($urandom % 71)) % 72;
        dec_todo.push_back(mk_dec(words[w], a, c, -1, "R7"));
      end
      // Positions 3, 9, 67 combine to 73: out of range, odd weight.
      dec_todo.push_back(mk_dec(words[w], data_index(3), data_index(9), data_index(67), "R8"));
    end

    enc_have = 0; dec_have = 0; enc_acc = 0; dec_acc = 0; enc_stall = 0; dec_stall = 0;
    enc_prev = '0; dec_prev_d = '0; dec_prev_s = '0; enc_cur = '0; enc_prev_data = '0;

    while (enc_todo.size() != 0 || enc_have || enc_exp.size() != 0 ||
           dec_todo.size() != 0 || dec_have || dec_exp.size() != 0) begin
      @(negedge clk);
      // -------- observe outputs of the last edge --------
      if (enc_acc) check(enc_out_valid, "R9", "enc latency", enc_out_valid, 1);
      if (dec_acc) check(dec_out_valid, "R9", "dec latency", dec_out_valid, 1);
      if (enc_stall) check(enc_out_valid && enc_out_code == enc_prev, "R9", "enc stall hold", enc_out_code, enc_prev);
      if (dec_stall) check(dec_out_valid && dec_out_data == dec_prev_d && dec_out_syndrome == dec_prev_s,
                           "R9", "dec stall hold", {dec_out_data, dec_out_syndrome}, {dec_prev_d, dec_prev_s});
      if (enc_out_valid) begin
        if (enc_exp.size() == 0) check(0, "R9", "enc spurious valid", enc_out_code, 0);
        else begin
          check(enc_out_code == enc_exp[0], "R1", "codeword", enc_out_code, enc_exp[0]);
          check(!(^enc_out_code), "R2", "codeword parity", ^enc_out_code, 0);
        end
      end
      if (dec_out_valid) begin
        if (dec_exp.size() == 0) check(0, "R9", "dec spurious valid", dec_out_data, 0);
        else begin
          ex = dec_exp[0];
          check(dec_out_data == ex.data, ex.tag, "data", dec_out_data, ex.data);
          check(dec_out_syndrome == ex.syn, ex.tag, "syndrome", dec_out_syndrome, ex.syn);
          check(dec_out_corrected == ex.corr && dec_out_uncorrectable == ex.unc, ex.tag, "flags",
                {dec_out_corrected, dec_out_uncorrectable}, {ex.corr, ex.unc});
        end
      end
      // -------- drive next cycle --------
      enc_out_ready = ($urandom % 4) != 0;
      dec_out_ready = ($urandom % 4) != 0;
      if (!enc_have && enc_todo.size() != 0 && ($urandom % 3) != 0) begin
        enc_cur = enc_todo.pop_front();
        enc_have = 1;
      end
      if (!dec_have && dec_todo.size() != 0 && ($urandom % 3) != 0) begin
        dec_cur = dec_todo.pop_front();
        dec_have = 1;
      end
      enc_in_valid = enc_have;
      enc_in_data  = enc_cur;
      dec_in_valid = dec_have;
      dec_in_code  = dec_have ? dec_cur.code : '0;
      #1;
      enc_acc = enc_in_valid && enc_in_ready;
      dec_acc = dec_in_valid && dec_in_ready;
      if (enc_out_valid && enc_out_ready && enc_exp.size() != 0) void'(enc_exp.pop_front());
      if (dec_out_valid && dec_out_ready && dec_exp.size() != 0) void'(dec_exp.pop_front());
      if (enc_acc) begin
        enc_exp.push_back(encode(enc_cur));
        enc_have = 0;
      end
      if (dec_acc) begin
        dec_exp.push_back(dec_cur);
        dec_have = 0;
      end
      enc_stall  = enc_out_valid && !enc_out_ready;
      dec_stall  = dec_out_valid && !dec_out_ready;
      enc_prev   = enc_out_code;
      dec_prev_d = dec_out_data;
      dec_prev_s = dec_out_syndrome;
    end

    @(negedge clk);
    enc_in_valid = 1'b0;
    dec_in_valid = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule